// File: doc/BRIEF.md
# Stacked-Carrier Disposition PWM Modulator

This block drives one phase leg of a nine-level cascaded H-bridge converter. It builds a set of triangular carriers, one per amplitude band. There are twice as many carriers as isolated DC cells, so four cells give eight carriers. The bands are stacked edge to edge around zero and together cover the whole signed reference range. Every carrier is compared with the latest reference sample. The block outputs one compare bit per carrier and the phase level that the bits imply, from -4 to +4.

All carriers share one up/down counter, so they share one period and one amplitude. A carrier that must run 180 degrees out of phase uses the bitwise complement of the counter. Four run-time arrangements choose which bands are complemented. A requested change of arrangement is applied only at the end of a carrier period. Reference samples arrive on a valid/ready stream. The block never applies back-pressure, so ready is held high. A sample is captured on every cycle where valid is high. When valid is low the last captured sample is kept.

Top module: `mcpwm_modulator`

## Requirements
- R1: While `rst` is high, `cmp_bits` is 0 and `out_level` is -4. The triangle counter starts at 0 and rises, the arrangement is same-phase, and the held reference is 0.
- R2: With defaults (8-bit reference, band width B = 32), carrier k (k = 0..7) equals (k-4)*B + t, where t is 0..31. Bit k of `cmp_bits` is 1 exactly when the held reference is strictly greater than carrier k. The counter moves one step every `step_div`+1 clocks. It climbs 0 to 31, then falls back to 0, and each end value occurs once per turn.
- R3: `disp_mode` = 0 (same-phase): t equals the counter value for every band.
- R4: `disp_mode` = 1 (inverted): t equals 31 minus the counter value for every band.
- R5: `disp_mode` = 2 (split about zero): bands 4..7 use the counter value, and bands 0..3 use 31 minus it.
- R6: `disp_mode` = 3 (alternating): even bands use the counter value, and odd bands use 31 minus it.
- R7: `out_level` equals the number of set compare bits minus 4. The set bits always form a contiguous run starting at bit 0.
- R8: A held reference of -128 gives level -4 in every cycle. A held reference of +127 gives +4, except when carrier 7 sits at its peak of 127, where it gives +3.
- R9: A new `disp_mode` is adopted only on the counter step that leaves 0. Until then the previous arrangement stays in force.
- R10: `ref_ready` is always 1. `ref_sample` is captured on each clock with `ref_valid` high and held otherwise. The outputs reflect the held reference, counter and arrangement one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step_div | input | 8 | Clocks per counter step, minus one |
| disp_mode | input | 2 | Carrier arrangement request (0 same, 1 inverted, 2 split, 3 alternating) |
| ref_valid | input | 1 | Reference sample valid |
| ref_ready | output | 1 | Always high; no back-pressure |
| ref_sample | input | 8 | Signed reference sample |
| cmp_bits | output | 8 | Per-carrier compare result, bit k for band k |
| out_level | output | 4 | Signed phase level, -4..+4 |

## Verification
The main risk is an internal state that drifts out of step with the requirements, and a stray state of this kind shows up at the ports within one output clock. A counter that skips a step or turns at the wrong value shifts the clock in which a compare bit toggles for a mid-band reference. The comparison then fails within one counter step. A mode latched at the wrong time flips the complemented bands, and the level disagrees on the first clock where the reference lies inside a flipped band. A lost or stale reference sample changes which bands are set on the next cycle. A wrong level sum breaks the link between the count and the bits on that same clock.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;

  typedef enum logic [1:0] {
    DISP_SAME  = 2'd0,
    DISP_INV   = 2'd1,
    DISP_SPLIT = 2'd2,
    DISP_ALT   = 2'd3
  } disp_e;

  // Whether band k of ncar uses the complemented counter under arrangement m.
  function automatic logic band_flipped(disp_e m, int k, int ncar);
    logic f;
    unique case (m)
      DISP_SAME:  f = 1'b0;
      DISP_INV:   f = 1'b1;
      DISP_SPLIT: f = (k < ncar / 2);
      DISP_ALT:   f = (k % 2) == 1;
      default:    f = 1'b0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/mcpwm_tri_counter.sv
module mcpwm_tri_counter #(
  parameter int CNT_W = 5,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_set,
  output logic [CNT_W-1:0] tri_cnt,
  output logic             tick,
  output logic             at_min
);
  localparam logic [CNT_W-1:0] TOP_V = '1;

  logic [DIV_W-1:0] pre_cnt;
  logic             going_up;

  assign tick   = (pre_cnt >= div_set);
  assign at_min = (tri_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
    end else if (tick) begin
      pre_cnt <= '0;
    end else begin
      pre_cnt <= pre_cnt + DIV_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tri_cnt  <= '0;
      going_up <= 1'b1;
    end else if (tick) begin
      if (going_up) begin
        if (tri_cnt == TOP_V) begin
          going_up <= 1'b0;
          tri_cnt  <= tri_cnt - CNT_W'(1);
        end else begin
          tri_cnt  <= tri_cnt + CNT_W'(1);
        end
      end else begin
        if (tri_cnt == '0) begin
          going_up <= 1'b1;
          tri_cnt  <= CNT_W'(1);
        end else begin
          tri_cnt  <= tri_cnt - CNT_W'(1);
        end
      end
    end
  end

  // R2
  tri_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((tri_cnt == $past(tri_cnt)) ||
              (tri_cnt == $past(tri_cnt) + CNT_W'(1)) ||
              (tri_cnt == $past(tri_cnt) - CNT_W'(1))));

  // R2
  tri_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(tri_cnt));

endmodule

// File: rtl/mcpwm_mode_gate.sv
module mcpwm_mode_gate
  import mcpwm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  tick,
  input  logic  at_min,
  input  disp_e mode_req,
  output disp_e mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= DISP_SAME;
    end else if (tick && at_min) begin
      mode_q <= mode_req;
    end
  end

  // R9
  mode_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> ($past(tick) && $past(at_min)));

endmodule

// File: rtl/mcpwm_band_compare.sv
module mcpwm_band_compare
  import mcpwm_pkg::*;
#(
  parameter int REF_W = 8,
  parameter int NCAR  = 8,
  parameter int CNT_W = 5
) (
  input  logic signed [REF_W-1:0] ref_q,
  input  logic        [CNT_W-1:0] tri_cnt,
  input  disp_e                   mode_q,
  output logic        [NCAR-1:0]  hit
);
  localparam int BAND_W = REF_W - CNT_W;

  for (genvar k = 0; k < NCAR; k++) begin : g_band
    localparam logic [BAND_W-1:0] BAND_TOP = BAND_W'(k ^ (NCAR / 2));
    logic                    flip;
    logic signed [REF_W-1:0] carrier;
    always_comb begin
      flip    = band_flipped(mode_q, k, NCAR);
      carrier = {BAND_TOP, (flip ? ~tri_cnt : tri_cnt)};
    end
    assign hit[k] = (ref_q > carrier);
  end

endmodule

// File: rtl/mcpwm_level_sum.sv
module mcpwm_level_sum #(
  parameter int NCAR  = 8,
  parameter int NCELL = 4,
  parameter int LVL_W = 4
) (
  input  logic        [NCAR-1:0]  hit,
  output logic signed [LVL_W-1:0] level
);
  always_comb begin
    int cnt;
    cnt = 0;
    for (int i = 0; i < NCAR; i++) begin
      cnt += int'(hit[i]);
    end
    level = LVL_W'(cnt - NCELL);
  end
endmodule

// File: rtl/mcpwm_modulator.sv
module mcpwm_modulator
  import mcpwm_pkg::*;
#(
  parameter int REF_W = 8,
  parameter int NCELL = 4,
  parameter int DIV_W = 8,
  localparam int NCAR   = 2 * NCELL,
  localparam int BAND_W = $clog2(NCAR),
  localparam int CNT_W  = REF_W - BAND_W,
  localparam int LVL_W  = $clog2(NCELL + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic        [DIV_W-1:0] step_div,
  input  logic        [1:0]       disp_mode,
  input  logic                    ref_valid,
  output logic                    ref_ready,
  input  logic signed [REF_W-1:0] ref_sample,
  output logic        [NCAR-1:0]  cmp_bits,
  output logic signed [LVL_W-1:0] out_level
);
  localparam logic signed [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

  logic signed [REF_W-1:0] ref_q;
  logic        [CNT_W-1:0] tri_cnt;
  logic                    tick;
  logic                    at_min;
  disp_e                   mode_q;
  logic        [NCAR-1:0]  hit;
  logic signed [LVL_W-1:0] level_c;

  assign ref_ready = 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else if (ref_valid) begin
      ref_q <= ref_sample;
    end
  end

  mcpwm_tri_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tri (
    .clk(clk), .rst(rst), .div_set(step_div),
    .tri_cnt(tri_cnt), .tick(tick), .at_min(at_min)
  );

  mcpwm_mode_gate u_mode (
    .clk(clk), .rst(rst), .tick(tick), .at_min(at_min),
    .mode_req(disp_e'(disp_mode)), .mode_q(mode_q)
  );

  mcpwm_band_compare #(.REF_W(REF_W), .NCAR(NCAR), .CNT_W(CNT_W)) u_cmp (
    .ref_q(ref_q), .tri_cnt(tri_cnt), .mode_q(mode_q), .hit(hit)
  );

  mcpwm_level_sum #(.NCAR(NCAR), .NCELL(NCELL), .LVL_W(LVL_W)) u_sum (
    .hit(hit), .level(level_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_bits  <= '0;
      out_level <= LVL_W'(-NCELL);
    end else begin
      cmp_bits  <= hit;
      out_level <= level_c;
    end
  end

  // R7
  therm_chk: assert property (@(posedge clk) disable iff (rst)
    ((cmp_bits + NCAR'(1)) & cmp_bits) == '0);

  // R7
  level_match_chk: assert property (@(posedge clk) disable iff (rst)
    int'(out_level) == ($countones(cmp_bits) - NCELL));

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (rst)
    (ref_q == REF_MIN) |=> (int'(out_level) == -NCELL));

  // R10
  ref_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> $stable(ref_q));

endmodule

// File: tb/sim_mcpwm_modulator.sv
module sim_mcpwm_modulator;
  localparam int B = 32;

  logic              clk = 1'b0;
  logic              rst;
  logic [7:0]        step_div;
  logic [1:0]        disp_mode;
  logic              ref_valid;
  logic              ref_ready;
  logic signed [7:0] ref_sample;
  logic [7:0]        cmp_bits;
  logic signed [3:0] out_level;

  always #2 clk = ~clk;

  mcpwm_modulator u0 (
    .clk(clk), .rst(rst), .step_div(step_div), .disp_mode(disp_mode),
    .ref_valid(ref_valid), .ref_ready(ref_ready), .ref_sample(ref_sample),
    .cmp_bits(cmp_bits), .out_level(out_level)
  );

  typedef struct {
    logic [7:0] g;
    int         lv;
    string      tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Model state, as the requirements define it
  int m_pre, m_tri, m_up, m_mode, m_ref;

  function automatic exp_t predict(string tag);
    exp_t e;
    int cnt;
    cnt = 0;
    for (int k = 0; k < 8; k++) begin
      bit flip;
      int car;
      case (m_mode)
        0: flip = 0;
        1: flip = 1;
        2: flip = (k < 4);
        default: flip = (k % 2 == 1);
      endcase
      car = (k - 4) * B + (flip ? (B - 1 - m_tri) : m_tri);
      e.g[k] = (m_ref > car);
      cnt += int'(e.g[k]);
    end
    e.lv  = cnt - 4;
    e.tag = tag;
    return e;
  endfunction

  task automatic step(input int mode, input int div, input int refv,
                      input bit valid, input string tag);
    string t;
    t = (mode != m_mode) ? "R9" : tag;
    q.push_back(predict(t));
    if (m_pre >= div) begin
      m_pre = 0;
      if (m_tri == 0) m_mode = mode;
      if (m_up == 1) begin
        if (m_tri == B - 1) begin m_up = 0; m_tri = m_tri - 1; end
        else m_tri = m_tri + 1;
      end else begin
        if (m_tri == 0) begin m_up = 1; m_tri = 1; end
        else m_tri = m_tri - 1;
      end
    end else begin
      m_pre = m_pre + 1;
    end
    if (valid) m_ref = refv;
    step_div   = 8'(div);
    disp_mode  = 2'(mode);
    ref_valid  = valid;
    ref_sample = 8'(refv);
    @(negedge clk);
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_cmp++;
        if (cmp_bits !== e.g || int'(out_level) != e.lv) begin
          n_bad++;
          $display("FAIL %s: bits=%b level=%0d expected bits=%b level=%0d",
                   e.tag, cmp_bits, out_level, e.g, e.lv);
        end
        n_cmp++;
        if (int'(out_level) != $countones(cmp_bits) - 4 ||
            ((cmp_bits + 8'd1) & cmp_bits) != 8'd0) begin
          n_bad++;
          $display("FAIL R7: bits=%b level=%0d expected level=%0d thermometer",
                   cmp_bits, out_level, $countones(cmp_bits) - 4);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Driver
  initial begin
    rst = 1'b1; step_div = '0; disp_mode = '0; ref_valid = 1'b0; ref_sample = '0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (cmp_bits !== 8'd0 || out_level !== -4'sd4) begin
      n_bad++;
      $display("FAIL R1: bits=%b level=%0d expected bits=00000000 level=-4",
               cmp_bits, out_level);
    end
    m_pre = 0; m_tri = 0; m_up = 1; m_mode = 0; m_ref = 0;
    rst = 1'b0;
    step(0, 0, 0, 1'b0, "R1");
    for (int i = 0; i < 150; i++)
      step(0, 0, ((i * 23) % 256) - 128, 1'b1, (i < 70) ? "R2" : "R3");
    for (int i = 0; i < 160; i++)
      step(1, 0, ((i * 29 + 5) % 256) - 128, 1'b1, "R4");
    for (int i = 0; i < 400; i++)
      step(2, 2, ((i * 17 + 3) % 256) - 128, 1'b1, "R5");
    for (int i = 0; i < 300; i++)
      step(3, 1, ((i * 41 + 7) % 256) - 128, 1'b1, "R6");
    for (int i = 0; i < 400; i++)
      step(i / 100, 0, ((i / 7) % 2 == 0) ? -128 : 127, 1'b1, "R8");
    for (int i = 0; i < 120; i++)
      step(2, 0, (i % 3 == 0) ? (((i * 13) % 256) - 128) : ((i * 71) % 256) - 128,
           (i % 3 == 0), "R10");
    n_cmp++;
    if (ref_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R10: ref_ready=%b expected 1", ref_ready);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule